// File: doc/BRIEF.md
# Host serial register port

This block gives a host processor a four-wire serial path into the small control and status space of a line transceiver. The host lowers an active-low select, clocks a 16-bit frame in on a serial clock, and either writes an 8-bit value or reads one back on a serial data output. All port inputs are brought into the block's own clock domain through synchronizer flops, and edges of the serial clock are detected there. The serial output pin is modelled as a data bit plus an output enable.

Two status flags record line events: loss of signal and a driver performance monitor alarm. Each flag latches when its event input rises. While either flag is set, an open-drain, active-low interrupt is pulled low. The host releases the interrupt by writing ones to the flags it has serviced. A clock-edge input selects whether read data is meant to be sampled by the host on rising or on falling serial clock edges.

Top module: `host_serial_port`

## Requirements
- R1: A frame is 16 bits, each sampled on a rising serial clock edge while select is low, least significant bit first within each field: bit 0 is the direction (1 = read, 0 = write), bits 1-5 the register address, bits 6-7 ignored, bits 8-15 the data. Address 0 is the status register (bit 0 loss of signal, bit 1 monitor alarm, upper bits read 0) and address 1 is an 8-bit read/write control register.
- R2: In a read, the eight data bits leave on the serial output least significant first. With the clock-edge input low, each bit changes after a rising edge and is meant to be sampled on the falling edge, the first bit following the eighth rising edge. With it high, each bit changes after a falling edge and is meant to be sampled on the rising edge, the first bit following the falling edge after the eighth rising edge.
- R3: The serial output enable is low whenever select is high and during the whole of a write frame.
- R4: A write frame updates the addressed register once its sixteenth bit is taken; the update takes effect on the fourth clock edge after the sixteenth rising serial clock edge reaches the port (two synchronizer stages, edge detection, frame register).
- R5: If select rises before sixteen bits have been taken, the frame is abandoned and no register changes.
- R6: A status flag is set by a low-to-high transition of its event input; an event input that merely stays high does not set the flag again after it has been cleared.
- R7: Writing to the status register clears each flag whose data bit is 1 and leaves a flag whose data bit is 0 unchanged.
- R8: When an event edge and a clear of the same flag land on the same clock cycle, the flag ends up set.
- R9: The interrupt output enable is high while either status flag is set and low otherwise; the interrupt data output is constant 0, so the line reads low only while a flag is set.
- R10: Addresses other than 0 and 1 read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| clke | input | 1 | Output edge select: 1 = host samples on rising edge |
| los_evt | input | 1 | Loss-of-signal event level |
| dpm_evt | input | 1 | Performance monitor event level |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for sdo |
| int_oe | output | 1 | Interrupt pull-down enable |
| int_o | output | 1 | Interrupt drive value, always 0 |

## Verification
On every cycle the assertions check that a register write comes only from a selected frame and never while the output is enabled, that the serial output changes only right after the clock edge chosen by the clock-edge input, that an event edge sets its flag, that a cleared-or-held flag behaves as written, and that the interrupt is released only after a write. Whether a read frame returns the right bits in the right order on either edge setting, whether an early select release truly leaves the register untouched, unmapped addresses, and the exact cycle at which an event beats a clear can only be shown by the bench's scenarios, which drive whole frames and read the registers back through the port.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    // Field position within a serial frame
    typedef enum logic [1:0] {
        PH_DIR  = 2'd0,
        PH_ADDR = 2'd1,
        PH_PAD  = 2'd2,
        PH_DATA = 2'd3
    } frame_phase_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int               W       = 1,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hsp_frame.sv
module hsp_frame
    import hsp_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PAD_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic              clke,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int HDR_LEN   = 1 + ADDR_W + PAD_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] C_LEN      = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] rsh;
        logic              sdo;
        logic              wr;
    } frame_t;

    frame_t       fr_d, fr_q;
    frame_phase_e phase;

    always_comb begin
        if (fr_q.cnt == '0)              phase = PH_DIR;
        else if (fr_q.cnt <= C_ADDR_END) phase = PH_ADDR;
        else if (fr_q.cnt < C_HDR)       phase = PH_PAD;
        else                             phase = PH_DATA;
    end

    always_comb begin
        fr_d    = fr_q;
        fr_d.wr = 1'b0;
        if (cs_n_s) begin
            fr_d.cnt = '0;
            fr_d.rd  = 1'b0;
            fr_d.sdo = 1'b0;
            fr_d.rsh = '0;
        end else if (sclk_rise && fr_q.cnt != C_LEN) begin
            fr_d.cnt = fr_q.cnt + 1'b1;
            case (phase)
                PH_DIR:  fr_d.rd   = sdi_s;
                PH_ADDR: fr_d.addr = {sdi_s, fr_q.addr[ADDR_W-1:1]};
                PH_DATA: fr_d.data = {sdi_s, fr_q.data[DATA_W-1:1]};
                default: ;
            endcase
            if (fr_q.cnt == C_LAST && !fr_q.rd) fr_d.wr = 1'b1;
            if (fr_q.rd && fr_q.cnt == C_HDR_LAST) begin
                if (clke) begin
                    fr_d.rsh = rd_data;
                end else begin
                    fr_d.sdo = rd_data[0];
                    fr_d.rsh = rd_data >> 1;
                end
            end else if (fr_q.rd && phase == PH_DATA && !clke) begin
                fr_d.sdo = fr_q.rsh[0];
                fr_d.rsh = fr_q.rsh >> 1;
            end
        end else if (sclk_fall && fr_q.rd && clke && fr_q.cnt >= C_HDR) begin
            fr_d.sdo = fr_q.rsh[0];
            fr_d.rsh = fr_q.rsh >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign addr    = fr_q.addr;
    assign wr_en   = fr_q.wr;
    assign wr_data = fr_q.data;
    assign sdo     = fr_q.sdo;
    assign sdo_oe  = !cs_n_s && fr_q.rd;

    // R4: a write strobe only ever follows a cycle with select low
    assert_wr_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!cs_n_s));

    // R2: driven data moves only right after the chosen serial clock edge
    assert_sdo_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$stable(sdo) && $stable(clke))
            |-> $past(clke ? sclk_fall : sclk_rise));
endmodule

// File: rtl/hsp_regs.sv
module hsp_regs #(
    parameter int                ADDR_W    = 5,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              los_evt,
    input  logic              dpm_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              los;
        logic              dpm;
        logic              los_prev;
        logic              dpm_prev;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  stat_wr, los_rise, dpm_rise;

    assign stat_wr  = wr_en && addr == STAT_ADDR;
    assign los_rise = los_evt && !rg_q.los_prev;
    assign dpm_rise = dpm_evt && !rg_q.dpm_prev;

    always_comb begin
        rg_d          = rg_q;
        rg_d.los_prev = los_evt;
        rg_d.dpm_prev = dpm_evt;
        if (stat_wr && wr_data[0]) rg_d.los = 1'b0;
        if (stat_wr && wr_data[1]) rg_d.dpm = 1'b0;
        if (los_rise) rg_d.los = 1'b1;
        if (dpm_rise) rg_d.dpm = 1'b1;
        if (wr_en && addr == CTRL_ADDR) rg_d.ctrl = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == STAT_ADDR)      rd_data[1:0] = {rg_q.dpm, rg_q.los};
        else if (addr == CTRL_ADDR) rd_data      = rg_q.ctrl;
    end

    assign irq = rg_q.los | rg_q.dpm;

    // R6 / R8: an event edge always leaves its flag set, clear or not
    assert_evt_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_evt) |=> rg_q.los);

    // R7: a one written to the flag clears it when no edge competes
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_data[0] && !los_rise) |=> !rg_q.los);

    // R7: without a clearing write the flag keeps its value
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.dpm && !(stat_wr && wr_data[1])) |=> rg_q.dpm);
endmodule

// File: rtl/host_serial_port.sv
module host_serial_port #(
    parameter int ADDR_W      = 5,
    parameter int PAD_W       = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    input  logic clke,
    input  logic los_evt,
    input  logic dpm_evt,
    output logic sdo,
    output logic sdo_oe,
    output logic int_oe,
    output logic int_o
);
    localparam int SYN_W = 4;

    typedef struct packed {
        logic sclk_prev;
    } edge_t;

    edge_t             eg_d, eg_q;
    logic [SYN_W-1:0]  syn_out;
    logic              cs_n_s, sclk_s, sdi_s, clke_s;
    logic              sclk_rise, sclk_fall;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data, rd_data;

    hsp_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({clke, sdi, sclk, cs_n}),
        .dout (syn_out)
    );
    assign {clke_s, sdi_s, sclk_s, cs_n_s} = syn_out;

    always_comb begin
        eg_d.sclk_prev = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eg_q <= '0;
        else        eg_q <= eg_d;
    end

    assign sclk_rise = sclk_s && !eg_q.sclk_prev;
    assign sclk_fall = !sclk_s && eg_q.sclk_prev;

    hsp_frame #(.ADDR_W(ADDR_W), .PAD_W(PAD_W), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sdi_s    (sdi_s),
        .clke     (clke_s),
        .rd_data  (rd_data),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    hsp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .STAT_ADDR(ADDR_W'(0)), .CTRL_ADDR(ADDR_W'(1))) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .los_evt(los_evt),
        .dpm_evt(dpm_evt),
        .rd_data(rd_data),
        .irq    (int_oe)
    );

    assign int_o = 1'b0;

    // R3: no write strobe while the output is being driven
    assert_float_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !wr_en);

    // R9: the interrupt is released only right after a register write
    assert_int_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_oe) |-> $past(wr_en));

    // R9: a monitor event edge pulls the interrupt one cycle later
    assert_int_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpm_evt) |=> int_oe);
endmodule

// File: tb/tb_host_serial_port.sv
module tb_host_serial_port;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, clke = 1'b0;
    logic los_evt = 1'b0, dpm_evt = 1'b0;
    logic sdo, sdo_oe, int_oe, int_o;
    wire  int_line = int_oe ? int_o : 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    host_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .clke(clke), .los_evt(los_evt), .dpm_evt(dpm_evt),
        .sdo(sdo), .sdo_oe(sdo_oe), .int_oe(int_oe), .int_o(int_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame; nbits < 16 abandons it; evt_at >= 0 raises los_evt that
    // many cycles after the last rising serial clock edge.
    task automatic xfer(input bit rd, input logic [4:0] a, input logic [7:0] wd,
                        input bit ce, input int nbits, input int evt_at,
                        output logic [7:0] rdv, output bit oe_seen);
        rdv = '0;
        oe_seen = 1'b0;
        clke = ce;
        cyc(H);
        cs_n = 1'b0;
        cyc(H);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0)      sdi = rd;
            else if (i < 6)  sdi = a[i-1];
            else if (i < 8)  sdi = 1'b0;
            else             sdi = wd[i-8];
            cyc(H);
            if (ce && i >= 8) rdv[i-8] = sdo;
            oe_seen |= sdo_oe;
            sclk = 1'b1;
            if (i == 15 && evt_at >= 0) begin
                cyc(evt_at);
                los_evt = 1'b1;
                cyc(H - evt_at);
            end else begin
                cyc(H);
            end
            if (!ce && i >= 7 && i <= 14) rdv[i-7] = sdo;
            oe_seen |= sdo_oe;
            sclk = 1'b0;
        end
        cyc(H);
        cs_n = 1'b1;
        cyc(H);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input bit ce);
        logic [7:0] r;
        bit o;
        xfer(1'b0, a, d, ce, 16, -1, r, o);
    endtask

    task automatic rdreg(input logic [4:0] a, input bit ce, output logic [7:0] r);
        bit o;
        xfer(1'b1, a, 8'h00, ce, 16, -1, r, o);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        chk(sdo_oe == 1'b0, "R3 reset float", sdo_oe, 0);
        chk(int_line == 1'b1, "R9 reset int idle", int_line, 1);
        rdreg(5'd1, 1'b0, r);
        chk(r == 8'h00, "R4 reset ctrl", r, 0);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h00, "R1 reset status", r, 0);
    endtask

    task automatic t_ctrl;
        logic [7:0] r;
        bit o;
        xfer(1'b0, 5'd1, 8'hA5, 1'b0, 16, -1, r, o);
        chk(o == 1'b0, "R3 float during write", o, 0);
        rdreg(5'd1, 1'b0, r);
        chk(r == 8'hA5, "R1 R4 ctrl read falling sample", r, 8'hA5);
        wr(5'd1, 8'h3C, 1'b1);
        xfer(1'b1, 5'd1, 8'h00, 1'b1, 16, -1, r, o);
        chk(r == 8'h3C, "R2 ctrl read rising sample", r, 8'h3C);
        chk(o == 1'b1, "R3 driven during read", o, 1);
        chk(sdo_oe == 1'b0, "R3 float after deselect", sdo_oe, 0);
        wr(5'd1, 8'h81, 1'b0);
        rdreg(5'd1, 1'b1, r);
        chk(r == 8'h81, "R2 edge-bit pattern rising sample", r, 8'h81);
    endtask

    task automatic t_abort;
        logic [7:0] r;
        bit o;
        xfer(1'b0, 5'd1, 8'hFF, 1'b0, 12, -1, r, o);
        rdreg(5'd1, 1'b0, r);
        chk(r == 8'h81, "R5 abort after 12 bits", r, 8'h81);
        xfer(1'b0, 5'd1, 8'h00, 1'b1, 15, -1, r, o);
        rdreg(5'd1, 1'b0, r);
        chk(r == 8'h81, "R5 abort after 15 bits", r, 8'h81);
    endtask

    task automatic t_unmapped;
        logic [7:0] r;
        wr(5'd5, 8'h77, 1'b0);
        rdreg(5'd5, 1'b0, r);
        chk(r == 8'h00, "R10 unmapped reads zero", r, 0);
        rdreg(5'd1, 1'b0, r);
        chk(r == 8'h81, "R10 unmapped write ignored", r, 8'h81);
    endtask

    task automatic t_status;
        logic [7:0] r;
        los_evt = 1'b1;
        cyc(4);
        chk(int_line == 1'b0, "R9 int low on loss", int_line, 0);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h01, "R6 loss flag latched", r, 1);
        wr(5'd0, 8'h00, 1'b0);
        rdreg(5'd0, 1'b1, r);
        chk(r == 8'h01, "R7 zero write keeps flag", r, 1);
        wr(5'd0, 8'h01, 1'b0);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h00, "R6 R7 held level no relatch", r, 0);
        chk(int_line == 1'b1, "R9 int released", int_line, 1);
        los_evt = 1'b0;
        dpm_evt = 1'b1;
        cyc(4);
        dpm_evt = 1'b0;
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h02, "R6 monitor flag latched", r, 2);
        chk(int_line == 1'b0, "R9 int low on monitor", int_line, 0);
        wr(5'd0, 8'h01, 1'b0);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h02, "R7 other flag untouched", r, 2);
        wr(5'd0, 8'h02, 1'b0);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h00, "R7 monitor cleared", r, 0);
        chk(int_line == 1'b1, "R9 int idle again", int_line, 1);
    endtask

    task automatic t_priority;
        logic [7:0] r;
        bit o;
        // edge one cycle before the clear: the clear wins
        xfer(1'b0, 5'd0, 8'h01, 1'b0, 16, 2, r, o);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h00, "R4 R8 edge before clear is cleared", r, 0);
        los_evt = 1'b0;
        cyc(4);
        // edge on the clear cycle: the event wins
        xfer(1'b0, 5'd0, 8'h01, 1'b0, 16, 3, r, o);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h01, "R8 edge with clear stays set", r, 1);
        chk(int_line == 1'b0, "R9 int after priority", int_line, 0);
        los_evt = 1'b0;
        wr(5'd0, 8'h01, 1'b0);
        rdreg(5'd0, 1'b0, r);
        chk(r == 8'h00, "R7 final clear", r, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_ctrl();
        t_abort();
        t_unmapped();
        t_status();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule